// File: doc/BRIEF.md
# Row-Aware DRAM Request Scheduler

This block holds a short queue of pending DRAM bursts, each tagged with a rank, a bank and a row. Every cycle it looks at the whole queue in age order against the state of each bank. That state is the open row, the earliest time a column command may go, the earliest time an activate or precharge may go, and whether the rank is free. From this it names one entry to serve next. The choice ranks a row hit whose column command can go without a bubble first. Next comes a request to a closed or different row whose activate or precharge can overlap work elsewhere. Last comes a row hit that has to wait for its column slot. When the controller asks for a decision, the chosen entry is moved to the head of the queue with the other entries keeping their order. The controller then issues from the head.

The scheduler also counts column accesses per bank to the row that is open. Once a bank reaches the configured limit, the block raises a close request for that bank. From then on, requests to that row are no longer treated as row hits.

Top module: `row_aware_sched`

## Requirements
- R1: A push while fewer than DEPTH entries are held appends the entry at the tail. A push while DEPTH entries are held is dropped and leaves the queue as it was. `full` is high exactly when DEPTH entries are held.
- R2: `issue` with a non-empty queue removes the head entry and moves every younger entry up one place. When `issue` and `sched` are high together, only the removal happens.
- R3: An entry whose rank bit in `rank_avail` is low is never granted.
- R4: The column threshold is the larger of `now` and (`bus_busy_until` + extra − T_CL), where a negative difference is taken as 0. The extra term is T_CS when `dir_switched` is high and 0 otherwise. A bank's column or prep time equal to the threshold counts as in time.
- R5: An entry is seamless when it is a row hit and its bank's column time is at or below the threshold. A row hit means the bank has an open row, that row equals the entry's row, and the bank's close request is low. The oldest seamless entry (lowest index) is granted, with `sel_class` = 1.
- R6: An entry is hidden-prep when it is not a row hit and its bank's prep time is at or below the threshold. If no seamless entry exists, the oldest hidden-prep entry is granted, with `sel_class` = 2.
- R7: An entry is prepped when it is a row hit whose column time is past the threshold. It is granted, oldest first with `sel_class` = 3, only when no seamless and no hidden-prep entry exists.
- R8: When no held entry qualifies, `grant` is zero, `grant_vld` is low and `sel_class` is 0. A `sched` in that cycle leaves the queue unchanged.
- R9: `sched` without `issue` and with a grant moves the granted entry to the head. Entries older than it shift back one place and younger entries stay where they are.
- R10: On an `issue`, the head's bank counter is incremented if the head is a row hit, and is set to 1 otherwise. `force_close[k]` is high while bank k's counter has reached MAX_ACC. Bank index k is rank × NBANK + bank. Reset clears all counters.
- R11: Entries to a bank whose `force_close` is high are classed as non-hits. They are hidden-prep if the bank's prep time is in time, and otherwise do not qualify.
- R12: `grant` has at most one bit set, and `grant_vld` equals the OR of `grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Append an entry this cycle |
| push_rank | input | RK_W | Rank of the new entry |
| push_bank | input | BK_W | Bank within the rank of the new entry |
| push_row | input | ROW_W | Row of the new entry |
| issue | input | 1 | Remove the head entry |
| sched | input | 1 | Move the granted entry to the head |
| open_vld | input | NRANK*NBANK | Bank has an open row |
| open_row | input | NRANK*NBANK*ROW_W | Open row per bank |
| col_at | input | NRANK*NBANK*T_W | Earliest column time per bank |
| prep_at | input | NRANK*NBANK*T_W | Earliest activate/precharge time per bank |
| rank_avail | input | NRANK | Rank free for commands |
| now | input | T_W | Current time |
| bus_busy_until | input | T_W | Data bus busy until |
| dir_switched | input | 1 | Bus direction just changed |
| grant | output | DEPTH | One-hot index of the chosen entry |
| grant_vld | output | 1 | An entry qualifies |
| sel_class | output | 2 | 0 none, 1 seamless, 2 hidden-prep, 3 prepped |
| q_count | output | $clog2(DEPTH+1) | Entries held |
| full | output | 1 | Queue holds DEPTH entries |
| head_vld | output | 1 | Head entry present |
| head_rank | output | RK_W | Head entry rank |
| head_bank | output | BK_W | Head entry bank |
| head_row | output | ROW_W | Head entry row |
| force_close | output | NRANK*NBANK | Row-close request per bank |

## Verification
The bench builds the block with DEPTH 4, two ranks of four banks, 2-bit rows, 6-bit times, T_CL 5, T_CS 3 and MAX_ACC 3. With only four rows per bank, row hits are common, so all three classes compete within one queue. A limit of three accesses lets a short run of issues raise a close request. With 6-bit times, the threshold often hits the clamp at zero and often lands exactly on a bank's column or prep time.

// File: rtl/row_aware_sched.sv
module row_aware_sched #(
  parameter int DEPTH   = 8,
  parameter int NRANK   = 2,
  parameter int NBANK   = 8,
  parameter int ROW_W   = 14,
  parameter int T_W     = 16,
  parameter int T_CL    = 14,
  parameter int T_CS    = 2,
  parameter int MAX_ACC = 16,
  localparam int RK_W   = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BK_W   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int NBT    = NRANK * NBANK,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [RK_W-1:0]    push_rank,
  input  logic [BK_W-1:0]    push_bank,
  input  logic [ROW_W-1:0]   push_row,
  input  logic               issue,
  input  logic               sched,
  input  logic [NBT-1:0]     open_vld,
  input  logic [NBT*ROW_W-1:0] open_row,
  input  logic [NBT*T_W-1:0] col_at,
  input  logic [NBT*T_W-1:0] prep_at,
  input  logic [NRANK-1:0]   rank_avail,
  input  logic [T_W-1:0]     now,
  input  logic [T_W-1:0]     bus_busy_until,
  input  logic               dir_switched,
  output logic [DEPTH-1:0]   grant,
  output logic               grant_vld,
  output logic [1:0]         sel_class,
  output logic [CNT_W-1:0]   q_count,
  output logic               full,
  output logic               head_vld,
  output logic [RK_W-1:0]    head_rank,
  output logic [BK_W-1:0]    head_bank,
  output logic [ROW_W-1:0]   head_row,
  output logic [NBT-1:0]     force_close
);
  localparam int ACC_W = $clog2(MAX_ACC + 1);
  localparam logic [T_W:0] CL_L = (T_W+1)'(T_CL);
  localparam logic [T_W:0] CS_L = (T_W+1)'(T_CS);

  logic [RK_W-1:0]  q_rank [DEPTH];
  logic [BK_W-1:0]  q_bank [DEPTH];
  logic [ROW_W-1:0] q_row  [DEPTH];
  logic [CNT_W-1:0] q_cnt;
  logic [ACC_W-1:0] acc [NBT];

  logic [RK_W-1:0]  n_rank [DEPTH];
  logic [BK_W-1:0]  n_bank [DEPTH];
  logic [ROW_W-1:0] n_row  [DEPTH];
  logic [CNT_W-1:0] n_cnt;

  logic [T_W:0] sum_t, base_t, min_col;
  assign sum_t   = {1'b0, bus_busy_until} + (dir_switched ? CS_L : '0);
  assign base_t  = (sum_t >= CL_L) ? sum_t - CL_L : '0;
  assign min_col = (base_t > {1'b0, now}) ? base_t : {1'b0, now};

  for (genvar k = 0; k < NBT; k++) begin : g_close
    assign force_close[k] = acc[k] >= ACC_W'(MAX_ACC);
  end

  logic [DEPTH-1:0] seam_v, hid_v, prep_v;
  always_comb begin
    int  b;
    logic elig, hit, col_ok;
    seam_v = '0;
    hid_v  = '0;
    prep_v = '0;
    for (int i = 0; i < DEPTH; i++) begin
      b = int'(q_rank[i]) * NBANK + int'(q_bank[i]);
      elig = (CNT_W'(i) < q_cnt) && (b < NBT) && rank_avail[q_rank[i]];
      if (b >= NBT) b = 0;
      hit = open_vld[b] && (open_row[b*ROW_W +: ROW_W] == q_row[i]) && !force_close[b];
      col_ok = {1'b0, col_at[b*T_W +: T_W]} <= min_col;
      seam_v[i] = elig && hit && col_ok;
      prep_v[i] = elig && hit && !col_ok;
      hid_v[i]  = elig && !hit && ({1'b0, prep_at[b*T_W +: T_W]} <= min_col);
    end
  end

  always_comb begin
    if (|seam_v) begin
      grant = seam_v & (~seam_v + 1'b1);
      sel_class = 2'd1;
    end else if (|hid_v) begin
      grant = hid_v & (~hid_v + 1'b1);
      sel_class = 2'd2;
    end else if (|prep_v) begin
      grant = prep_v & (~prep_v + 1'b1);
      sel_class = 2'd3;
    end else begin
      grant = '0;
      sel_class = 2'd0;
    end
  end
  assign grant_vld = |grant;

  logic [IDX_W-1:0] g_idx;
  always_comb begin
    g_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) g_idx = IDX_W'(i);
  end

  logic do_pop;
  assign do_pop   = issue && (q_cnt != '0);
  assign q_count  = q_cnt;
  assign full     = q_cnt == CNT_W'(DEPTH);
  assign head_vld = q_cnt != '0;
  assign head_rank = q_rank[0];
  assign head_bank = q_bank[0];
  assign head_row  = q_row[0];

  int   head_b;
  logic head_hit;
  always_comb begin
    head_b = int'(q_rank[0]) * NBANK + int'(q_bank[0]);
    if (head_b >= NBT) head_b = 0;
    head_hit = open_vld[head_b] && (open_row[head_b*ROW_W +: ROW_W] == q_row[0])
               && !force_close[head_b];
  end

  always_comb begin
    n_rank = q_rank;
    n_bank = q_bank;
    n_row  = q_row;
    n_cnt  = q_cnt;
    if (do_pop) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        n_rank[k] = q_rank[k+1];
        n_bank[k] = q_bank[k+1];
        n_row[k]  = q_row[k+1];
      end
      n_cnt = q_cnt - 1'b1;
    end else if (sched && grant_vld) begin
      n_rank[0] = q_rank[g_idx];
      n_bank[0] = q_bank[g_idx];
      n_row[0]  = q_row[g_idx];
      for (int k = 1; k < DEPTH; k++) begin
        if (k <= int'(g_idx)) begin
          n_rank[k] = q_rank[k-1];
          n_bank[k] = q_bank[k-1];
          n_row[k]  = q_row[k-1];
        end
      end
    end
    if (push_valid && !full) begin
      n_rank[n_cnt[IDX_W-1:0]] = push_rank;
      n_bank[n_cnt[IDX_W-1:0]] = push_bank;
      n_row[n_cnt[IDX_W-1:0]]  = push_row;
      n_cnt = n_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        q_rank[k] <= '0;
        q_bank[k] <= '0;
        q_row[k]  <= '0;
      end
      for (int k = 0; k < NBT; k++) acc[k] <= '0;
    end else begin
      q_cnt  <= n_cnt;
      q_rank <= n_rank;
      q_bank <= n_bank;
      q_row  <= n_row;
      for (int k = 0; k < NBT; k++)
        if (do_pop && k == head_b)
          acc[k] <= head_hit ? acc[k] + 1'b1 : ACC_W'(1);
    end
  end
endmodule

module row_aware_sched_chk #(
  parameter int DEPTH = 8,
  parameter int NRANK = 2,
  parameter int RK_W  = 1,
  parameter int BK_W  = 3,
  parameter int ROW_W = 14,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             issue,
  input logic             sched,
  input logic [DEPTH-1:0] grant,
  input logic             grant_vld,
  input logic [1:0]       sel_class,
  input logic [CNT_W-1:0] q_count,
  input logic [NRANK-1:0] rank_avail,
  input logic [RK_W-1:0]  head_rank,
  input logic [BK_W-1:0]  head_bank,
  input logic [ROW_W-1:0] head_row,
  input logic [RK_W-1:0]  q_rank [DEPTH],
  input logic [BK_W-1:0]  q_bank [DEPTH],
  input logic [ROW_W-1:0] q_row  [DEPTH]
);
  logic [RK_W-1:0]  g_rank;
  logic [BK_W-1:0]  g_bank;
  logic [ROW_W-1:0] g_row;
  always_comb begin
    g_rank = '0;
    g_bank = '0;
    g_row  = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) begin
        g_rank = q_rank[i];
        g_bank = q_bank[i];
        g_row  = q_row[i];
      end
  end

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_vld == (grant != '0)));

  assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && q_count == CNT_W'(DEPTH) && !issue) |=> $stable(q_count));

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  assert_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && q_count != '0 && !push_valid) |=> q_count == $past(q_count) - 1'b1);

  assert_rank_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> rank_avail[g_rank]);

  assert_none_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> sel_class == 2'd0);

  assert_move_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && grant_vld && !issue) |=>
      (head_rank == $past(g_rank) && head_bank == $past(g_bank) && head_row == $past(g_row)));
endmodule

bind row_aware_sched row_aware_sched_chk #(
  .DEPTH(DEPTH), .NRANK(NRANK), .RK_W(RK_W), .BK_W(BK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .issue(issue), .sched(sched),
  .grant(grant), .grant_vld(grant_vld), .sel_class(sel_class), .q_count(q_count),
  .rank_avail(rank_avail), .head_rank(head_rank), .head_bank(head_bank),
  .head_row(head_row), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row)
);

// File: tb/row_aware_sched_bench.sv
module row_aware_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, NRANK = 2, NBANK = 4, ROW_W = 2, T_W = 6;
  localparam int T_CL = 5, T_CS = 3, MAX_ACC = 3;
  localparam int NBT = NRANK * NBANK;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, issue = 0, sched = 0, dir_switched = 0;
  logic [0:0] push_rank = 0;
  logic [1:0] push_bank = 0;
  logic [ROW_W-1:0] push_row = 0;
  logic [NBT-1:0] open_vld = 0;
  logic [NBT*ROW_W-1:0] open_row = 0;
  logic [NBT*T_W-1:0] col_at = 0, prep_at = 0;
  logic [NRANK-1:0] rank_avail = '1;
  logic [T_W-1:0] now = 0, bus_busy_until = 0;
  logic [DEPTH-1:0] grant;
  logic grant_vld, full, head_vld;
  logic [1:0] sel_class;
  logic [2:0] q_count;
  logic [0:0] head_rank;
  logic [1:0] head_bank;
  logic [ROW_W-1:0] head_row;
  logic [NBT-1:0] force_close;

  row_aware_sched #(.DEPTH(DEPTH), .NRANK(NRANK), .NBANK(NBANK), .ROW_W(ROW_W),
    .T_W(T_W), .T_CL(T_CL), .T_CS(T_CS), .MAX_ACC(MAX_ACC)) u_row_aware_sched (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_rank(push_rank),
    .push_bank(push_bank), .push_row(push_row), .issue(issue), .sched(sched),
    .open_vld(open_vld), .open_row(open_row), .col_at(col_at), .prep_at(prep_at),
    .rank_avail(rank_avail), .now(now), .bus_busy_until(bus_busy_until),
    .dir_switched(dir_switched), .grant(grant), .grant_vld(grant_vld),
    .sel_class(sel_class), .q_count(q_count), .full(full), .head_vld(head_vld),
    .head_rank(head_rank), .head_bank(head_bank), .head_row(head_row),
    .force_close(force_close));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int mq_rank [DEPTH], mq_bank [DEPTH], mq_row [DEPTH];
  int mcnt = 0;
  int macc [NBT];

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int min_col();
    int s;
    s = int'(bus_busy_until) + (dir_switched ? T_CS : 0) - T_CL;
    if (s < 0) s = 0;
    if (int'(now) > s) s = int'(now);
    return s;
  endfunction

  function automatic void exp_sel(output int cls, output int idx);
    int f1, f2, f3, m, b;
    bit hit;
    f1 = -1; f2 = -1; f3 = -1;
    m = min_col();
    for (int i = 0; i < mcnt; i++) begin
      b = mq_rank[i] * NBANK + mq_bank[i];
      if (!rank_avail[mq_rank[i]]) continue;
      hit = open_vld[b] && int'(open_row[b*ROW_W +: ROW_W]) == mq_row[i] && macc[b] < MAX_ACC;
      if (hit) begin
        if (int'(col_at[b*T_W +: T_W]) <= m) begin if (f1 < 0) f1 = i; end
        else if (f3 < 0) f3 = i;
      end else if (int'(prep_at[b*T_W +: T_W]) <= m) begin
        if (f2 < 0) f2 = i;
      end
    end
    if (f1 >= 0) begin cls = 1; idx = f1; end
    else if (f2 >= 0) begin cls = 2; idx = f2; end
    else if (f3 >= 0) begin cls = 3; idx = f3; end
    else begin cls = 0; idx = 0; end
  endfunction

  function automatic int exp_close();
    int v = 0;
    for (int k = 0; k < NBT; k++) if (macc[k] >= MAX_ACC) v |= (1 << k);
    return v;
  endfunction

  task automatic cyc(input bit p, input bit is, input bit sc, input int pr, input int pb, input int prow);
    int cls, idx, b, old_cnt, tr, tb, tw;
    string tag;
    bit hit;
    @(negedge clk);
    push_valid = p; issue = is; sched = sc;
    push_rank = pr[0:0]; push_bank = pb[1:0]; push_row = prow[ROW_W-1:0];
    #1;
    exp_sel(cls, idx);
    tag = cls == 1 ? "R5" : cls == 2 ? "R6" : cls == 3 ? "R7" : "R8";
    chk(sel_class, cls, tag);
    chk(grant, cls != 0 ? (1 << idx) : 0, tag);
    chk(grant_vld, cls != 0, "R12");
    @(posedge clk);
    old_cnt = mcnt;
    if (is && mcnt > 0) begin
      b = mq_rank[0] * NBANK + mq_bank[0];
      hit = open_vld[b] && int'(open_row[b*ROW_W +: ROW_W]) == mq_row[0] && macc[b] < MAX_ACC;
      macc[b] = hit ? macc[b] + 1 : 1;
      for (int k = 0; k < DEPTH - 1; k++) begin
        mq_rank[k] = mq_rank[k+1]; mq_bank[k] = mq_bank[k+1]; mq_row[k] = mq_row[k+1];
      end
      mcnt--;
    end else if (sc && cls != 0) begin
      tr = mq_rank[idx]; tb = mq_bank[idx]; tw = mq_row[idx];
      for (int k = idx; k > 0; k--) begin
        mq_rank[k] = mq_rank[k-1]; mq_bank[k] = mq_bank[k-1]; mq_row[k] = mq_row[k-1];
      end
      mq_rank[0] = tr; mq_bank[0] = tb; mq_row[0] = tw;
    end
    if (p && old_cnt < DEPTH) begin
      mq_rank[mcnt] = pr; mq_bank[mcnt] = pb; mq_row[mcnt] = prow;
      mcnt++;
    end
    #1;
    chk(q_count, mcnt, "R1");
    chk(full, mcnt == DEPTH, "R1");
    chk(head_vld, mcnt > 0, "R2");
    if (mcnt > 0) begin
      tag = is ? "R2" : "R9";
      chk(head_rank, mq_rank[0], tag);
      chk(head_bank, mq_bank[0], tag);
      chk(head_row, mq_row[0], tag);
    end
    chk(force_close, exp_close(), "R10");
  endtask

  task automatic peek(input int exp_cls, input string tag);
    @(negedge clk);
    push_valid = 0; issue = 0; sched = 0;
    #1;
    chk(sel_class, exp_cls, tag);
  endtask

  task automatic set_bank(input int b, input bit ov, input int row, input int ca, input int pa);
    open_vld[b] = ov;
    open_row[b*ROW_W +: ROW_W] = row[ROW_W-1:0];
    col_at[b*T_W +: T_W] = ca[T_W-1:0];
    prep_at[b*T_W +: T_W] = pa[T_W-1:0];
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NBT; k++) macc[k] = 0;
    for (int k = 0; k < NBT; k++) set_bank(k, 0, 0, 63, 63);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // reset state (R1, R10, R8)
    chk(q_count, 0, "R1");
    chk(full, 0, "R1");
    chk(force_close, 0, "R10");
    chk(grant_vld, 0, "R8");

    // R4: threshold and direction-switch penalty
    set_bank(0, 1, 1, 7, 63);
    bus_busy_until = 10; now = 0; dir_switched = 0;
    cyc(1, 0, 0, 0, 0, 1);
    peek(3, "R4");
    dir_switched = 1;
    peek(1, "R4");
    dir_switched = 0; now = 7;
    peek(1, "R4");
    now = 0;
    // R3: rank unavailable
    rank_avail = 2'b10;
    peek(0, "R3");
    rank_avail = 2'b11;
    // R6 beats R7, then R9 move
    set_bank(1, 0, 0, 63, 0);
    cyc(1, 0, 0, 0, 1, 2);
    peek(2, "R6");
    cyc(0, 0, 1, 0, 0, 0);
    chk(head_bank, 1, "R9");
    // R2: issue beats sched
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R10/R11: close after limit
    set_bank(2, 1, 3, 0, 63);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 2, 3);
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0, 0);
    chk(force_close[2], 1, "R10");
    cyc(1, 0, 0, 0, 2, 3);
    peek(0, "R11");
    set_bank(2, 1, 3, 0, 0);
    peek(2, "R11");
    cyc(0, 1, 0, 0, 0, 0);
    chk(force_close[2], 0, "R10");
    // R1: overfill
    for (int k = 0; k < DEPTH + 1; k++) cyc(1, 0, 0, k % 2, k % 4, k % 4);
    chk(full, 1, "R1");

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      for (int k = 0; k < NBT; k++)
        set_bank(k, $urandom % 4 != 0, $urandom % 4, $urandom % 64, $urandom % 64);
      for (int r = 0; r < NRANK; r++) rank_avail[r] = ($urandom % 4) != 0;
      now = 6'($urandom % 32);
      bus_busy_until = 6'($urandom % 64);
      dir_switched = $urandom % 2;
      cyc($urandom % 3 != 0, $urandom % 4 == 0, $urandom % 2,
          $urandom % 2, $urandom % 4, $urandom % 4);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule